// File: doc/BRIEF.md
# Ethernet Frame Padder and FCS Appender

This stage works on a stream one byte wide, in the transmit clock domain. Each frame it receives already holds the destination address, the source address and the EtherType, and the payload follows them. The stage forwards every byte unchanged. A frame shorter than the minimum pre-check length (60 bytes by default) gets zero bytes added until it reaches that length. A CRC-32 is computed over every byte the stage emits, pad bytes included, and the four-byte frame check sequence is appended after them. Every frame therefore leaves at least 64 bytes long.

Both sides use a valid/ready handshake. Each byte carries a last-byte flag and an abort flag. While a frame's data bytes are passing, the stage is combinational from input to output: `in_ready` follows `out_ready` and the output shows the input byte. Once the last input byte has been accepted, the stage holds `in_ready` low and generates the pad bytes and check bytes itself. The last-byte flag moves to the fourth check byte. An abort seen anywhere in the frame is reported on that same final byte.

The controller has three states:
- S_DATA passes data bytes through.
- S_PAD emits zero bytes.
- S_FCS emits the four check bytes.

The named transitions are:
- T_LAST_SHORT (S_DATA to S_PAD): the last byte is accepted while fewer than 59 bytes have already gone out.
- T_LAST_LONG (S_DATA to S_FCS): the last byte is accepted once 59 or more bytes have gone out.
- T_PAD_DONE (S_PAD to S_FCS): the pad byte that brings the frame to the minimum length is accepted.
- T_FCS_DONE (S_FCS to S_DATA): the fourth check byte is accepted. This transition also reinitialises the CRC, the byte count and the abort flag.

Top module: `eth_pad_fcs`

## Requirements
- R1: In S_DATA, an input byte is accepted exactly when `in_valid` and `out_ready` are both high. The byte appears on `out_data` in the same cycle with `out_last` low, and data bytes leave in their input order.
- R2: A frame of N < 60 input bytes is followed by 60 − N bytes of value 0x00 before its check bytes, so 60 data and pad bytes go out.
- R3: A frame of N ≥ 60 input bytes gets no pad bytes. Its check bytes follow the last input byte directly, so N + 4 bytes go out in total.
- R4: The check value is the CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and a final complement. It is computed over all emitted data and pad bytes, least significant bit of each byte first.
- R5: The four check bytes go out least significant byte first (check bits 7:0 first). `out_last` is high on the fourth check byte and on no other output byte.
- R6: From acceptance of the last input byte until the fourth check byte is accepted, `in_ready` is low and `out_valid` is high.
- R7: If any accepted byte of a frame had `in_abort` high, `out_abort` is high on that frame's fourth check byte. `out_abort` is low on every other byte, and on every byte of a frame with no abort.
- R8: After the fourth check byte, the CRC register, the byte count and the abort flag are reinitialised. The next frame's check value and padding are therefore independent of the previous frame.
- R9: While `out_valid` is high with `out_ready` low during pad or check bytes, `out_data` and `out_last` hold their values into the next cycle.
- R10: After reset, `out_valid` is low while no input is offered, and `out_last` and `out_abort` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Stage accepts the input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_abort | input | 1 | Frame is to be aborted |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last of its frame |
| out_abort | output | 1 | Abort marker, given on the final output byte |

## Verification
The case that needs the most care is a last input byte arriving while the count stands at 59. That byte closes the data phase and also completes the minimum length, so T_LAST_LONG must be taken with no pad byte. Frames of 58, 59, 60 and 61 bytes probe the two outcomes on either side of that point. The same moment can also carry an abort flag and a stalled output, so the sweep runs every length from 1 to 72 bytes, plus 100, both with and without random output backpressure and with aborts on some of the lengths. Each received frame is judged on its length, its pad bytes, its check bytes against an independent bitwise CRC model, and the position of the last and abort flags.

// File: rtl/eth_pad_fcs_pkg.sv
package eth_pad_fcs_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W = 32;
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        S_DATA = 2'd0,
        S_PAD  = 2'd1,
        S_FCS  = 2'd2
    } pf_state_t;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_next_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [BYTE_W-1:0] byte_in
    );
        logic [CRC_W-1:0] c;
        c = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};
        for (int b = 0; b < BYTE_W; b++) begin
            if (c[0]) begin
                c = (c >> 1) ^ CRC_POLY_REFL;
            end else begin
                c = c >> 1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_pf_crc.sv
module eth_pf_crc
    import eth_pad_fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  fcs
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            crc_q <= CRC_SEED;
        end else if (advance) begin
            crc_q <= crc_next_byte(crc_q, byte_in);
        end
    end

    assign fcs = ~crc_q;

endmodule

// File: rtl/eth_pf_count.sv
module eth_pf_count #(
    parameter int MIN_LEN = 60,
    localparam int CNT_W = $clog2(MIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             near_min
);

    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] EDGE_VAL = CNT_W'(MIN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (step && cnt_q != SAT_VAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    // The byte being emitted now completes the minimum length.
    assign near_min = (cnt_q >= EDGE_VAL);

endmodule

// File: rtl/eth_pf_ctrl.sv
module eth_pf_ctrl
    import eth_pad_fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_abort,
    input  logic              out_ready,
    input  logic              near_min,
    input  logic [CRC_W-1:0]  fcs,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              out_abort,
    output logic              byte_step,
    output logic              frame_done,
    output pf_state_t         state
);

    localparam int IDX_W = $clog2(FCS_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

    pf_state_t        state_q;
    pf_state_t        state_d;
    logic [IDX_W-1:0] idx_q;
    logic             abort_q;
    logic             fcs_final;

    assign state = state_q;
    assign fcs_final = (state_q == S_FCS) && (idx_q == IDX_LAST);

    // State register and per-frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_DATA;
            idx_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_done) begin
                idx_q   <= '0;
                abort_q <= 1'b0;
            end else begin
                if (state_q == S_FCS && out_ready) begin
                    idx_q <= idx_q + 1'b1;
                end
                if (in_valid && in_ready && in_abort) begin
                    abort_q <= 1'b1;
                end
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_data   = '0;
        out_last   = 1'b0;
        out_abort  = 1'b0;
        byte_step  = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            S_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                if (in_valid && out_ready) begin
                    byte_step = 1'b1;
                    if (in_last) begin
                        // T_LAST_LONG or T_LAST_SHORT
                        state_d = near_min ? S_FCS : S_PAD;
                    end
                end
            end
            S_PAD: begin
                out_valid = 1'b1;
                out_data  = '0;
                if (out_ready) begin
                    byte_step = 1'b1;
                    if (near_min) begin
                        state_d = S_FCS; // T_PAD_DONE
                    end
                end
            end
            S_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs[{idx_q, 3'b000} +: BYTE_W];
                out_last  = fcs_final;
                out_abort = fcs_final && abort_q;
                if (out_ready && fcs_final) begin
                    frame_done = 1'b1;
                    state_d    = S_DATA; // T_FCS_DONE
                end
            end
            default: begin
                state_d = S_DATA;
            end
        endcase
    end

endmodule

// File: rtl/eth_pad_fcs.sv
module eth_pad_fcs
    import eth_pad_fcs_pkg::*;
#(
    parameter int MIN_LEN = 60,
    localparam int CNT_W = $clog2(MIN_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_abort,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_abort
);

    logic             byte_step;
    logic             frame_done;
    logic             near_min;
    logic [CNT_W-1:0] count;
    logic [CRC_W-1:0] fcs;
    pf_state_t        state;

    eth_pf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_abort   (in_abort),
        .out_ready  (out_ready),
        .near_min   (near_min),
        .fcs        (fcs),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_abort  (out_abort),
        .byte_step  (byte_step),
        .frame_done (frame_done),
        .state      (state)
    );

    eth_pf_count #(.MIN_LEN(MIN_LEN)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (frame_done),
        .step     (byte_step),
        .count    (count),
        .near_min (near_min)
    );

    // The CRC sees exactly the bytes that leave the stage, pad bytes included.
    eth_pf_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_done),
        .advance (byte_step),
        .byte_in (out_data),
        .fcs     (fcs)
    );

endmodule

// File: rtl/eth_pad_fcs_chk.sv
module eth_pad_fcs_chk
    import eth_pad_fcs_pkg::*;
#(
    parameter int MIN_LEN = 60,
    localparam int CNT_W = $clog2(MIN_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             out_abort,
    input pf_state_t        state,
    input logic [CNT_W-1:0] count
);

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready && out_data == in_data && !out_last));

    // R6
    gen_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_DATA) |-> (!in_ready && out_valid));

    // R2
    pad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAD) |-> (count < CNT_W'(MIN_LEN)));

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != S_DATA)
        |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R7
    abort_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_abort) |-> out_last);

    // R5
    last_in_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (state == S_FCS));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (state == S_DATA && count == '0));

endmodule

bind eth_pad_fcs eth_pad_fcs_chk #(.MIN_LEN(MIN_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_abort (out_abort),
    .state     (state),
    .count     (count)
);

// File: tb/sim_eth_pad_fcs.sv
`timescale 1ns/1ps
module sim_eth_pad_fcs;

    localparam int MINL = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_abort = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_abort;

    int   checks = 0;
    int   errors = 0;
    int   rx_n = 0;
    int   frames_done = 0;
    int   cur_len = 1000;
    int   gen_viol = 0;
    bit   bp_on = 1'b0;
    logic [7:0] rx_data [0:255];
    logic       rx_last [0:255];
    logic       rx_abort [0:255];
    logic [7:0] exp_b [0:255];

    always #10 clk = ~clk;

    eth_pad_fcs u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_abort(in_abort),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_abort(out_abort)
    );

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 29 + i * 11 + 5) & 255);
    endfunction

    // Independent bit-serial model of the reflected CRC-32
    function automatic logic [31:0] model_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ exp_b[k][b];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Output monitor, sampling at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && in_ready && rx_n >= cur_len) gen_viol++;
            if (rst_n && out_valid && out_ready) begin
                if (rx_n < 256) begin
                    rx_data[rx_n]  = out_data;
                    rx_last[rx_n]  = out_last;
                    rx_abort[rx_n] = out_abort;
                end
                rx_n++;
                if (out_last) frames_done++;
            end
        end
    end

    // Output backpressure
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic send_frame(input int len, input bit ab);
        for (int i = 0; i < len; i++) begin
            bit got;
            in_valid = 1'b1;
            in_data  = pat(len, i);
            in_last  = (i == len - 1);
            in_abort = ab && (i == len - 1);
            do begin
                @(negedge clk);
                got = in_ready;
                @(posedge clk);
                #2;
            end while (!got);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_abort = 1'b0;
    endtask

    task automatic run_frame(input int len, input bit ab, input bit bp);
        int body;
        int exp_len;
        int bad_data;
        int bad_pad;
        int bad_last;
        int bad_abort;
        logic [31:0] fcs_exp;
        logic [31:0] fcs_got;
        int target;
        body = (len < MINL) ? MINL : len;
        exp_len = body + 4;
        bp_on = bp;
        rx_n = 0;
        gen_viol = 0;
        cur_len = len;
        target = frames_done + 1;
        send_frame(len, ab);
        while (frames_done < target) @(posedge clk);
        #2;
        cur_len = 1000;
        for (int i = 0; i < body; i++) exp_b[i] = (i < len) ? pat(len, i) : 8'h00;
        fcs_exp = model_crc(body);
        // R2 R3: frame length
        chk(rx_n == exp_len, (len < MINL) ? "R2 length" : "R3 length", rx_n, exp_len);
        bad_data = 0; bad_pad = 0; bad_last = 0; bad_abort = 0;
        for (int i = 0; i < exp_len && i < rx_n; i++) begin
            if (i < len && rx_data[i] !== pat(len, i)) bad_data++;
            if (i >= len && i < body && rx_data[i] !== 8'h00) bad_pad++;
            if (rx_last[i] !== (i == exp_len - 1)) bad_last++;
            if (rx_abort[i] !== (ab && i == exp_len - 1)) bad_abort++;
        end
        // R1 R9: data passes intact and in order, also under stalls
        chk(bad_data == 0, "R1 R9 data bytes", bad_data, 0);
        if (len < MINL) chk(bad_pad == 0, "R2 pad bytes zero", bad_pad, 0);
        fcs_got = {rx_data[body + 3], rx_data[body + 2], rx_data[body + 1], rx_data[body]};
        // R4 R5 R8: check value, byte order, fresh CRC per frame
        chk(fcs_got == fcs_exp, "R4 R5 R8 check bytes", fcs_got, fcs_exp);
        chk(bad_last == 0, "R5 last flag position", bad_last, 0);
        chk(bad_abort == 0, "R7 abort flag", bad_abort, 0);
        chk(gen_viol == 0, "R6 input blocked while generating", gen_viol, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        chk(out_last == 1'b0 && out_abort == 1'b0, "R10 flags after reset",
            {out_last, out_abort}, 0);
        @(posedge clk);
        #2;
        run_frame(14, 1'b0, 1'b0);
        run_frame(59, 1'b0, 1'b1);
        run_frame(60, 1'b1, 1'b1);
        run_frame(100, 1'b0, 1'b1);
        for (int len = 1; len <= 72; len++) begin
            run_frame(len, (len % 7) == 3, 1'b0);
            run_frame(len, (len % 5) == 1, 1'b1);
        end
        run_frame(100, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule